// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Switch Latch with Status Readback

This block is the digital core of an eight-channel low-side switch driver. A host talks to it over a four-wire serial link: an active-low chip select frames each transfer, a serial clock moves the bits, and there is one data line in each direction. While a frame is open, new switch commands shift in and a snapshot of channel status shifts out. Several devices can be daisy-chained by feeding each serial output into the next device's serial input. A frame of eight times n clocks then reaches n devices.

The serial pins are sampled by a system clock through a synchronizer, and edges are detected in that clock domain. An eight-bit command register drives the channel enables. The command takes effect only when a frame closes after a whole, nonzero number of bytes. Fault flags from the analog side act on the enables and on the readback: open load and short circuit per channel, and one global over-temperature flag. These flags never change the stored command. The serial output has a separate drive-enable, which the pad uses to float the line whenever chip select is high.

Top module: `serial_out_latch`

## Requirements
- R1: `sdo_oe` is 0 whenever the synchronized chip select is high, and 1 while a frame is open.
- R2: When chip select falls, the block captures a status byte into the shift path. Bit i of this byte is 1 only if command bit i is 1 and neither `open_flt[i]` nor `short_flt[i]` is set. The most significant bit appears on `sdo` before the first serial clock edge.
- R3: Serial input is sampled on each rising serial clock edge and enters at bit 0, so the first bit sent ends up as the most significant. `sdo` updates only on a falling serial clock edge or when chip select falls.
- R4: When chip select rises after a frame that contained a nonzero multiple of eight falling serial clock edges, the command register loads the last eight bits shifted in.
- R5: Any other falling-edge count, including zero, leaves the command register unchanged. The edge count starts from zero in every frame.
- R6: With two devices chained (upstream `sdo` into downstream `sdi`), a 16-clock frame loads the first byte sent into the downstream device and the second byte into the upstream device. The host reads back the downstream status byte first, then the upstream one.
- R7: Reset (`rst_n` low) clears the command register, turns all enables off and drops `sdo_oe`.
- R8: While `over_temp` is 1, all `ch_en` bits are 0. The command register keeps its value, and it still accepts writes.
- R9: `short_flt[i]` forces `ch_en[i]` to 0 and leaves the other channels alone. `open_flt` does not affect `ch_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the serial output pad |
| open_flt | input | 8 | Per-channel open-load flags |
| short_flt | input | 8 | Per-channel short-circuit flags |
| over_temp | input | 1 | Global over-temperature flag |
| ch_en | output | 8 | Channel enables to the power stages |

## Verification
The hardest case to reach from the ports is the daisy chain. There the upstream `sdo`, which is delayed through the synchronizer and changes on falling edges, must be stable at the downstream device's next rising edge. The full snapshot of one device must also travel through the other device's shift path. The bench instantiates two devices with shared select and clock and the serial link wired between them. It runs back-to-back 16-clock frames, so the second frame reads back the status that the first frame committed. Short frames (0, 7 and 9 edges) followed by a good frame show that a rejected count does not leak into the next frame.

// File: rtl/sol_pkg.sv
package sol_pkg;
  // Decoded serial-pin events in the system clock domain
  typedef struct packed {
    logic cs_low;
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic sclk_fall;
    logic sdi;
  } sol_evt_t;
endpackage

// File: rtl/sol_in_sync.sv
module sol_in_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output sol_pkg::sol_evt_t evt
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] IDLE = 3'b100; // cs_n high, sclk low, sdi low

  logic [NSIG-1:0] stage_q [STAGES];
  logic [NSIG-1:0] stage_d [STAGES];
  logic [NSIG-1:0] prev_q, prev_d;
  logic [NSIG-1:0] cur;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = {cs_n, sclk, sdi};
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= IDLE;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign cur    = stage_q[STAGES-1];
  assign prev_d = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= prev_d;
  end

  always_comb begin
    evt.cs_low    = ~cur[2];
    evt.cs_fall   = prev_q[2] & ~cur[2];
    evt.cs_rise   = ~prev_q[2] & cur[2];
    evt.sclk_rise = ~prev_q[1] & cur[1] & ~cur[2];
    evt.sclk_fall = prev_q[1] & ~cur[1] & ~cur[2];
    evt.sdi       = cur[0];
  end
endmodule

// File: rtl/sol_shifter.sv
module sol_shifter #(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sol_pkg::sol_evt_t evt,
  input  logic [WIDTH-1:0]  snap,
  output logic [WIDTH-1:0]  shift_q,
  output logic              sdo_q,
  output logic              commit
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] shift_d;
  logic             sdo_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             cnt_wrap;

  assign cnt_wrap = (cnt_q == CW'(WIDTH - 1));

  always_comb begin
    shift_d = shift_q;
    sdo_d   = sdo_q;
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    if (evt.cs_fall) begin
      shift_d = snap;
      sdo_d   = snap[WIDTH-1];
      cnt_d   = '0;
      seen_d  = 1'b0;
    end else if (evt.cs_rise) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      if (evt.sclk_rise) shift_d = {shift_q[WIDTH-2:0], evt.sdi};
      if (evt.sclk_fall) begin
        sdo_d  = shift_q[WIDTH-1];
        cnt_d  = cnt_wrap ? '0 : cnt_q + 1'b1;
        seen_d = 1'b1;
      end
    end
  end

  assign commit = evt.cs_rise & seen_q & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      sdo_q   <= 1'b0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      sdo_q   <= sdo_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
    end
  end

  // R3: serial output moves only on a falling serial edge or at frame start
  assert_sdo_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_q != $past(sdo_q)) |-> $past(evt.sclk_fall | evt.cs_fall));
  // R4: a load request only occurs when the frame closes
  assert_commit_at_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (evt.cs_rise && !evt.cs_low));
  // R5: the edge count is zero at the first serial edge of a frame
  assert_count_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt.cs_fall) |-> (cnt_q == '0 && !seen_q));
endmodule

// File: rtl/sol_out_latch.sv
module sol_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [WIDTH-1:0] shift_q,
  input  logic [WIDTH-1:0] open_flt,
  input  logic [WIDTH-1:0] short_flt,
  input  logic             over_temp,
  output logic [WIDTH-1:0] cmd_q,
  output logic [WIDTH-1:0] snap,
  output logic [WIDTH-1:0] ch_en
);
  logic [WIDTH-1:0] cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (commit) cmd_d = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_ch
      assign ch_en[i] = cmd_q[i] & ~short_flt[i] & ~over_temp;
      assign snap[i]  = cmd_q[i] & ~open_flt[i] & ~short_flt[i];
    end
  endgenerate

  // R5: the command register never changes without a load request
  assert_hold_without_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != $past(cmd_q)) |-> $past(commit));
  // R8: over-temperature alone does not disturb the stored command
  assert_ot_keeps_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && !commit) |=> $stable(cmd_q));
  // R9: a shorted channel is never enabled
  assert_short_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en & short_flt) == '0);
endmodule

// File: rtl/serial_out_latch.sv
module serial_out_latch #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [WIDTH-1:0] open_flt,
  input  logic [WIDTH-1:0] short_flt,
  input  logic             over_temp,
  output logic [WIDTH-1:0] ch_en
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  sol_pkg::sol_evt_t evt;
  logic [WIDTH-1:0]  shift_q;
  logic [WIDTH-1:0]  cmd_q;
  logic [WIDTH-1:0]  snap;
  logic              sdo_q;
  logic              commit;

  // Reset: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  sol_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .cs_n (cs_n),
    .sclk (sclk),
    .sdi  (sdi),
    .evt  (evt)
  );

  sol_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .evt    (evt),
    .snap   (snap),
    .shift_q(shift_q),
    .sdo_q  (sdo_q),
    .commit (commit)
  );

  sol_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .commit   (commit),
    .shift_q  (shift_q),
    .open_flt (open_flt),
    .short_flt(short_flt),
    .over_temp(over_temp),
    .cmd_q    (cmd_q),
    .snap     (snap),
    .ch_en    (ch_en)
  );

  assign sdo    = sdo_q;
  assign sdo_oe = evt.cs_low & rst_n_int;

  // R1: the output driver is off outside a frame
  assert_oe_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!evt.cs_low) |-> !sdo_oe);
  // R8: over-temperature silences every channel
  assert_ot_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    over_temp |-> (ch_en == '0));
endmodule

// File: tb/test_serial_out_latch.sv
module test_serial_out_latch;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;   // system clocks per serial half-period
  localparam int W          = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] open_flt = '0, short_flt = '0;
  logic over_temp = 1'b0;
  logic sdo_a, oe_a, sdo_b, oe_b, sdi_b;
  logic [W-1:0] en_a, en_b;
  int n_run = 0, n_fail = 0;
  logic [31:0] rd;
  logic oe_in_frame;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdi_b = oe_a ? sdo_a : 1'b0;

  serial_out_latch i_serial_out_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo_a), .sdo_oe(oe_a), .open_flt(open_flt), .short_flt(short_flt),
    .over_temp(over_temp), .ch_en(en_a));

  serial_out_latch i_serial_out_latch_2 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi_b),
    .sdo(sdo_b), .sdo_oe(oe_b), .open_flt('0), .short_flt('0),
    .over_temp(1'b0), .ch_en(en_b));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Open a frame, send nbits MSB first, read back the chain output before each rising edge
  task automatic frame(input int nbits, input logic [31:0] data, input logic from_b);
    rd = '0;
    cs_n = 1'b0;
    wait_clk(HALF);
    oe_in_frame = oe_a;
    for (int k = nbits - 1; k >= 0; k--) begin
      sdi = data[k];
      wait_clk(HALF);
      rd = {rd[30:0], (from_b ? sdo_b : sdo_a)};
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF + 2);
  endtask

  task automatic t_reset;
    check("R7 enables after reset", en_a, 8'h00);
    check("R7 oe after reset", oe_a, 1'b0);
    check("R1 oe idle", oe_b, 1'b0);
  endtask

  task automatic t_write;
    frame(8, 32'hA5, 1'b0);
    check("R4 byte loaded", en_a, 8'hA5);
    check("R1 oe in frame", oe_in_frame, 1'b1);
    check("R1 oe after frame", oe_a, 1'b0);
    frame(8, 32'hA5, 1'b0);
    check("R2 R3 readback MSB first", rd[7:0], 8'hA5);
  endtask

  task automatic t_bad_counts;
    frame(7, 32'h3C, 1'b0);
    check("R5 seven edges rejected", en_a, 8'hA5);
    frame(9, 32'h13C, 1'b0);
    check("R5 nine edges rejected", en_a, 8'hA5);
    frame(0, 32'h0, 1'b0);
    check("R5 empty frame rejected", en_a, 8'hA5);
    frame(8, 32'h3C, 1'b0);
    check("R5 count restarts after bad frame", en_a, 8'h3C);
  endtask

  task automatic t_faults;
    open_flt = 8'h04;
    wait_clk(2);
    check("R9 open does not gate enable", en_a, 8'h3C);
    frame(8, 32'h3C, 1'b0);
    check("R2 open clears readback bit", rd[7:0], 8'h38);
    short_flt = 8'h08;
    wait_clk(2);
    check("R9 short gates own channel", en_a, 8'h34);
    frame(8, 32'h3C, 1'b0);
    check("R2 short clears readback bit", rd[7:0], 8'h30);
    open_flt = '0; short_flt = '0;
    over_temp = 1'b1;
    wait_clk(2);
    check("R8 over-temp all off", en_a, 8'h00);
    frame(8, 32'h81, 1'b0);
    check("R8 readback ignores over-temp", rd[7:0], 8'h3C);
    check("R8 still off after write", en_a, 8'h00);
    over_temp = 1'b0;
    wait_clk(2);
    check("R8 stored command restored", en_a, 8'h81);
  endtask

  task automatic t_cascade;
    frame(16, 32'h1234, 1'b1);
    check("R6 upstream byte", en_a, 8'h34);
    check("R6 downstream byte", en_b, 8'h12);
    frame(16, 32'h5678, 1'b1);
    check("R6 chain readback order", rd[15:0], 16'h1234);
    check("R6 upstream second", en_a, 8'h78);
    check("R6 downstream second", en_b, 8'h56);
  endtask

  task automatic t_reset_mid;
    rst_n = 1'b0;
    wait_clk(2);
    check("R7 async reset clears", en_a, 8'h00);
    rst_n = 1'b1;
    wait_clk(6);
    check("R7 stays clear after release", en_a, 8'h00);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset;
    t_write;
    t_bad_counts;
    t_faults;
    t_cascade;
    t_reset_mid;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule